// File: doc/BRIEF.md
# External Data Access Router

This block sits between an 8051-class core and two data-memory targets: an on-chip expanded RAM of 768 bytes and a multiplexed external bus. For each single-cycle access request from the core it decides whether the access stays on chip or goes out to the bus. The decision uses an auxiliary control register and the addressing form of the request: a byte-indexed (register-indirect) access or a full 16-bit pointer access.

Internal accesses drive the RAM port during the request cycle and return a done pulse one clock later. External accesses run a fixed sequence of phases on the bus: address with ALE high, address latch, strobe, done. The same logic also generates the ALE output. ALE either runs free at half the clock rate or, when suppressed, pulses only for external data accesses and for code-constant reads that the core reports.

Top module: `movx_router`

## Requirements
- R1: After synchronous reset the control register reads 0x00, RD and WR are high, the low port is released, done is low and the high port holds 0xFF.
- R2: The control register answers at SFR address 0x8E. Bit 1 selects external-only routing and bit 0 suppresses free-running ALE. Bits 7..2 read as zero. A write to any other SFR address leaves the register unchanged, and reads at other addresses return 0x00.
- R3: With bit 1 clear, a pointer-form access below 0x0300 enables the RAM port in the request cycle with address bits 9..0. RD and WR stay high, and done rises in the next cycle carrying the RAM read byte.
- R4: With bit 1 clear, a pointer-form access at 0x0300 or above goes to the external bus.
- R5: With bit 1 clear, a byte-indexed access always stays internal, at address {2'b00, addr[7:0]}, and never moves RD or WR.
- R6: With bit 1 set, every access in either form goes to the external bus, and the RAM port stays disabled.
- R7: An external access accepted in cycle T has ALE high with the address on both ports in T+1 and ALE low in T+2. The strobe is low in T+3 through T+2+STROBE_CYC, and done is high in T+3+STROBE_CYC.
- R8: On an external store the low port drives the write byte while WR is low. On a load the low port is released, the byte present in the last strobe cycle is returned on rdata with done, and RD is the strobe.
- R9: A pointer-form external access loads the high port with address bits 15..8. A byte-indexed external access leaves the high port unchanged.
- R10: With bit 0 clear and no external access in progress, ALE inverts on every clock.
- R11: With bit 0 set and no external access in progress, ALE equals the code-constant ALE request input.
- R12: A request that arrives while an external access is in progress is ignored. It neither enables the RAM port nor restarts the sequence.
- R13: RD and WR are never low together and are low only in the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address for register access |
| sfr_we | input | 1 | SFR write enable |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data |
| req_valid | input | 1 | Single-cycle access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_dptr | input | 1 | 1 = pointer form (16-bit), 0 = byte-indexed form |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Store data |
| movc_ale_req | input | 1 | ALE request for code-constant reads |
| done | output | 1 | Access completion pulse |
| rdata | output | 8 | Load data, valid with done |
| iram_en | output | 1 | Expanded RAM enable |
| iram_we | output | 1 | Expanded RAM write enable |
| iram_addr | output | 10 | Expanded RAM address |
| iram_wdata | output | 8 | Expanded RAM write data |
| iram_rdata | input | 8 | Expanded RAM read data, valid the cycle after enable |
| p0_out | output | 8 | Low port address/data out |
| p0_oe | output | 1 | Low port output enable |
| p0_in | input | 8 | Low port data in |
| p2_out | output | 8 | High address port |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ale | output | 1 | Address latch enable |

## Verification
The assertions check on every cycle that RD and WR are exclusive, that the RAM port never overlaps a strobe, and that byte-indexed requests with the select bit clear stay internal. They also check that requests during a running sequence are dropped, that a byte-indexed access keeps the high port, and that ALE toggles freely when not suppressed. The exact phase placement, the data on the low port, the returned load bytes and the effect of the register on routing at the 0x02FF/0x0300 boundary can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every clock.

// File: rtl/movx_pkg.sv
// Shared types and constants for the external data access router.
// Assumes: one request at a time, phases advance once per clock.
package movx_pkg;

    // Phase of the external bus sequence
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_LATCH  = 3'd2,
        PH_STROBE = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    // Captured request fields
    typedef struct packed {
        logic        write;
        logic        dptr;
        logic [15:0] addr;
        logic [7:0]  wdata;
    } acc_req_t;

endpackage

// File: rtl/movx_aux_reg.sv
// Auxiliary control register: holds the external-only select and the
// ALE suppression bit. Answers reads and writes at one SFR address.
// Assumes: reserved bits are not stored and read as zero.
module movx_aux_reg #(
    parameter logic [7:0] SFR_ADDR = 8'h8E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_we,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    output logic       extram,
    output logic       aleoff
);

    logic hit;

    // Address match for this register
    always_comb hit = (sfr_addr == SFR_ADDR);

    // Store the two live bits on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            extram <= 1'b0;
            aleoff <= 1'b0;
        end else if (sfr_we && hit) begin
            extram <= sfr_wdata[1];
            aleoff <= sfr_wdata[0];
        end
    end

    // Read-back with reserved bits forced to zero
    always_comb sfr_rdata = hit ? {6'b000000, extram, aleoff} : 8'h00;

endmodule

// File: rtl/movx_route_dec.sv
// Route decoder: on an accepted request chooses the on-chip RAM or the
// external sequence and drives the RAM port for internal accesses.
// Assumes: the request is a single-cycle pulse; XRAM_LIMIT <= 2**IRAM_AW.
module movx_route_dec #(
    parameter int          IRAM_AW    = 10,
    parameter logic [15:0] XRAM_LIMIT = 16'h0300
) (
    input  logic               req_valid,
    input  logic               seq_idle,
    input  logic               extram,
    input  movx_pkg::acc_req_t req,
    output logic               iram_en,
    output logic               iram_we,
    output logic [IRAM_AW-1:0] iram_addr,
    output logic [7:0]         iram_wdata,
    output logic               ext_start
);

    localparam int PAD_W = IRAM_AW - 8;

    logic accept;
    logic go_ext;

    // Routing decision from select bit, addressing form and address
    always_comb begin
        accept = req_valid && seq_idle;
        go_ext = extram || (req.dptr && (req.addr >= XRAM_LIMIT));
    end

    // RAM port drive and external start
    always_comb begin
        iram_en    = accept && !go_ext;
        iram_we    = iram_en && req.write;
        iram_addr  = req.dptr ? req.addr[IRAM_AW-1:0] : {{PAD_W{1'b0}}, req.addr[7:0]};
        iram_wdata = req.wdata;
        ext_start  = accept && go_ext;
    end

endmodule

// File: rtl/movx_ext_seq.sv
// External bus sequencer: runs address, latch, strobe and done phases
// on the multiplexed ports, and generates ALE in all states.
// Assumes: STROBE_CYC >= 1; ext_start only while seq_idle is high.
module movx_ext_seq #(
    parameter int STROBE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_start,
    input  movx_pkg::acc_req_t req,
    input  logic               aleoff,
    input  logic               movc_ale_req,
    input  logic [7:0]         p0_in,
    output logic [7:0]         p0_out,
    output logic               p0_oe,
    output logic [7:0]         p2_out,
    output logic               rd_n,
    output logic               wr_n,
    output logic               ale,
    output logic               seq_idle,
    output logic               ext_done,
    output logic [7:0]         ext_rdata
);
    import movx_pkg::*;

    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

    phase_t           phase;
    acc_req_t         cur;
    logic [CNT_W-1:0] scnt;
    logic [7:0]       p2_q;
    logic             ale_tog;
    logic             in_strobe;

    // Phase progression and strobe length count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            scnt  <= '0;
        end else begin
            case (phase)
                PH_IDLE:   if (ext_start) phase <= PH_ADDR;
                PH_ADDR:   phase <= PH_LATCH;
                PH_LATCH:  begin
                    phase <= PH_STROBE;
                    scnt  <= CNT_LOAD;
                end
                PH_STROBE: begin
                    if (scnt == '0) phase <= PH_DONE;
                    else            scnt  <= scnt - 1'b1;
                end
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Capture request fields and the high address byte at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            p2_q <= 8'hFF;
        end else if (ext_start) begin
            cur <= req;
            if (req.dptr) p2_q <= req.addr[15:8];
        end
    end

    // Sample load data in the final strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_rdata <= 8'h00;
        else if (in_strobe && (scnt == '0) && !cur.write)
            ext_rdata <= p0_in;
    end

    // Free-running half-rate ALE source
    always_ff @(posedge clk) begin
        if (!rst_n) ale_tog <= 1'b0;
        else        ale_tog <= aleoff ? 1'b0 : !ale_tog;
    end

    // Port, strobe and ALE decode from the phase register
    always_comb begin
        in_strobe = (phase == PH_STROBE);
        seq_idle  = (phase == PH_IDLE);
        ext_done  = (phase == PH_DONE);
        rd_n      = !(in_strobe && !cur.write);
        wr_n      = !(in_strobe && cur.write);
        p2_out    = p2_q;
        p0_oe     = 1'b0;
        p0_out    = 8'h00;
        if (phase == PH_ADDR || phase == PH_LATCH) begin
            p0_oe  = 1'b1;
            p0_out = cur.addr[7:0];
        end else if (in_strobe && cur.write) begin
            p0_oe  = 1'b1;
            p0_out = cur.wdata;
        end
        if (phase == PH_IDLE)      ale = aleoff ? movc_ale_req : ale_tog;
        else if (phase == PH_ADDR) ale = 1'b1;
        else                       ale = 1'b0;
    end

endmodule

// File: rtl/movx_router.sv
// Top of the external data access router: register, route decoder and
// bus sequencer, plus the internal completion pulse and load data mux.
// Assumes: the core issues one-cycle requests and waits for done.
module movx_router #(
    parameter int          IRAM_AW    = 10,
    parameter logic [15:0] XRAM_LIMIT = 16'h0300,
    parameter int          STROBE_CYC = 3,
    parameter logic [7:0]  SFR_ADDR   = 8'h8E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         sfr_addr,
    input  logic               sfr_we,
    input  logic [7:0]         sfr_wdata,
    output logic [7:0]         sfr_rdata,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_dptr,
    input  logic [15:0]        req_addr,
    input  logic [7:0]         req_wdata,
    input  logic               movc_ale_req,
    output logic               done,
    output logic [7:0]         rdata,
    output logic               iram_en,
    output logic               iram_we,
    output logic [IRAM_AW-1:0] iram_addr,
    output logic [7:0]         iram_wdata,
    input  logic [7:0]         iram_rdata,
    output logic [7:0]         p0_out,
    output logic               p0_oe,
    input  logic [7:0]         p0_in,
    output logic [7:0]         p2_out,
    output logic               rd_n,
    output logic               wr_n,
    output logic               ale
);
    import movx_pkg::*;

    acc_req_t   req;
    logic       extram;
    logic       aleoff;
    logic       seq_idle;
    logic       ext_start;
    logic       ext_done;
    logic [7:0] ext_rdata;
    logic       int_done_q;

    // Bundle the request inputs
    always_comb req = '{write: req_write, dptr: req_dptr, addr: req_addr, wdata: req_wdata};

    movx_aux_reg #(.SFR_ADDR(SFR_ADDR)) u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_we    (sfr_we),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .extram    (extram),
        .aleoff    (aleoff)
    );

    movx_route_dec #(.IRAM_AW(IRAM_AW), .XRAM_LIMIT(XRAM_LIMIT)) u_dec (
        .req_valid  (req_valid),
        .seq_idle   (seq_idle),
        .extram     (extram),
        .req        (req),
        .iram_en    (iram_en),
        .iram_we    (iram_we),
        .iram_addr  (iram_addr),
        .iram_wdata (iram_wdata),
        .ext_start  (ext_start)
    );

    movx_ext_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_start    (ext_start),
        .req          (req),
        .aleoff       (aleoff),
        .movc_ale_req (movc_ale_req),
        .p0_in        (p0_in),
        .p0_out       (p0_out),
        .p0_oe        (p0_oe),
        .p2_out       (p2_out),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .ale          (ale),
        .seq_idle     (seq_idle),
        .ext_done     (ext_done),
        .ext_rdata    (ext_rdata)
    );

    // Internal access completes one clock after the RAM enable
    always_ff @(posedge clk) begin
        if (!rst_n) int_done_q <= 1'b0;
        else        int_done_q <= iram_en;
    end

    // Completion and load data selection
    always_comb begin
        done  = int_done_q || ext_done;
        rdata = int_done_q ? iram_rdata : ext_rdata;
    end

endmodule

// File: rtl/movx_router_chk.sv
// Checker for the router: per-cycle properties on strobes, routing and
// ALE. Attached to every movx_router instance by the bind below.
module movx_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_dptr,
    input logic       extram,
    input logic       aleoff,
    input logic       seq_idle,
    input logic       iram_en,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ale,
    input logic [7:0] p2_out
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R13

    AST_STROBE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !seq_idle); // R13

    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        iram_en |-> (rd_n && wr_n)); // R3

    AST_BYTE_FORM_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seq_idle && !req_dptr && !extram) |-> iram_en); // R5

    AST_SELECT_ALL_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        extram |-> !iram_en); // R6

    AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seq_idle) |-> !iram_en); // R12

    AST_BYTE_FORM_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seq_idle && !req_dptr) |=> $stable(p2_out)); // R9

    AST_ALE_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(seq_idle) && seq_idle && !$past(aleoff) && !aleoff)
        |-> (ale != $past(ale))); // R10

endmodule

bind movx_router movx_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dptr  (req_dptr),
    .extram    (extram),
    .aleoff    (aleoff),
    .seq_idle  (seq_idle),
    .iram_en   (iram_en),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ale       (ale),
    .p2_out    (p2_out)
);

// File: tb/movx_router_bench.sv
// Bench: behavioural per-cycle model compared with every output at each
// falling edge; stimulus changes 1 time unit after the rising edge.
module movx_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STROBE     = 3;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_dptr = 1'b0;
    logic [15:0] req_addr = 16'h0000;
    logic [7:0]  req_wdata = 8'h00;
    logic        movc_ale_req = 1'b0;
    logic        done;
    logic [7:0]  rdata;
    logic        iram_en, iram_we;
    logic [9:0]  iram_addr;
    logic [7:0]  iram_wdata;
    logic [7:0]  iram_rdata = 8'h3C;
    logic [7:0]  p0_out;
    logic        p0_oe;
    logic [7:0]  p0_in = 8'hA5;
    logic [7:0]  p2_out;
    logic        rd_n, wr_n, ale;

    int vectors = 0;
    int miscompares = 0;
    bit started = 0;
    bit finished = 0;

    // behavioural model state
    int m_cnt = -1;
    bit m_extram = 0, m_aleoff = 0, m_tog = 0;
    bit m_wr = 0, m_int_done = 0, m_int_rd = 0;
    int m_addr = 0, m_wdata = 0, m_rdata = 0, m_p2 = 'hFF;

    movx_router #(.STROBE_CYC(STROBE)) u_movx_router (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_dptr(req_dptr), .req_addr(req_addr),
        .req_wdata(req_wdata), .movc_ale_req(movc_ale_req), .done(done),
        .rdata(rdata), .iram_en(iram_en), .iram_we(iram_we),
        .iram_addr(iram_addr), .iram_wdata(iram_wdata), .iram_rdata(iram_rdata),
        .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
        .rd_n(rd_n), .wr_n(wr_n), .ale(ale)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cmp(input string tag, input string name, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    function automatic bit goes_ext(input bit sel, input bit dptr, input int a);
        return sel || (dptr && a >= 'h0300);
    endfunction

    // model update at the rising edge
    always @(posedge clk) begin
        bit acc, ext;
        started = 1;
        if (!rst_n) begin
            m_cnt = -1; m_extram = 0; m_aleoff = 0; m_tog = 0;
            m_wr = 0; m_int_done = 0; m_int_rd = 0; m_addr = 0;
            m_wdata = 0; m_rdata = 0; m_p2 = 'hFF;
        end else begin
            acc = req_valid && (m_cnt < 0);
            ext = goes_ext(m_extram, req_dptr, int'(req_addr));
            if (m_cnt == STROBE + 1 && !m_wr) m_rdata = int'(p0_in);
            if (m_cnt >= 0) m_cnt = (m_cnt == STROBE + 2) ? -1 : m_cnt + 1;
            m_int_done = acc && !ext;
            m_int_rd = !req_write;
            if (acc && ext) begin
                m_cnt = 0; m_wr = req_write; m_addr = int'(req_addr);
                m_wdata = int'(req_wdata);
                if (req_dptr) m_p2 = int'(req_addr[15:8]);
            end
            m_tog = m_aleoff ? 0 : !m_tog;
            if (sfr_we && sfr_addr == 8'h8E) begin
                m_extram = sfr_wdata[1]; m_aleoff = sfr_wdata[0];
            end
        end
    end

    // full output comparison at the falling edge
    always @(negedge clk) begin
        bit idle, acc, ext, strobe, exp_en, exp_done, exp_oe, exp_ale;
        int exp_p0;
        if (started && !finished) begin
            idle   = (m_cnt < 0);
            acc    = req_valid && idle;
            ext    = goes_ext(m_extram, req_dptr, int'(req_addr));
            strobe = (m_cnt >= 2) && (m_cnt <= STROBE + 1);
            exp_en = acc && !ext;
            cmp("R3 R5 R6 R12", "iram_en", int'(iram_en), int'(exp_en));
            if (exp_en) begin
                cmp("R3", "iram_we", int'(iram_we), int'(req_write));
                cmp("R5", "iram_addr", int'(iram_addr),
                    req_dptr ? int'(req_addr[9:0]) : int'(req_addr[7:0]));
                if (req_write) cmp("R3", "iram_wdata", int'(iram_wdata), int'(req_wdata));
            end
            cmp("R4 R6 R13", "rd_n", int'(rd_n), int'(!(strobe && !m_wr)));
            cmp("R4 R6 R13", "wr_n", int'(wr_n), int'(!(strobe && m_wr)));
            exp_oe = (m_cnt == 0 || m_cnt == 1) || (strobe && m_wr);
            exp_p0 = (m_cnt == 0 || m_cnt == 1) ? (m_addr & 'hFF) : m_wdata;
            cmp("R7 R8", "p0_oe", int'(p0_oe), int'(exp_oe));
            if (exp_oe) cmp("R7 R8", "p0_out", int'(p0_out), exp_p0);
            cmp("R9 R1", "p2_out", int'(p2_out), m_p2);
            exp_ale = idle ? (m_aleoff ? movc_ale_req : m_tog) : (m_cnt == 0);
            cmp("R7 R10 R11", "ale", int'(ale), int'(exp_ale));
            exp_done = m_int_done || (m_cnt == STROBE + 2);
            cmp("R3 R7", "done", int'(done), int'(exp_done));
            if (m_int_done && m_int_rd) cmp("R3", "rdata", int'(rdata), int'(iram_rdata));
            if (m_cnt == STROBE + 2 && !m_wr) cmp("R8", "rdata", int'(rdata), m_rdata);
            cmp("R2", "sfr_rdata", int'(sfr_rdata),
                (sfr_addr == 8'h8E) ? (int'(m_extram) * 2 + int'(m_aleoff)) : 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        @(posedge clk); #1;
        sfr_we = 1'b0; sfr_addr = 8'h8E;
    endtask

    task automatic access(input bit wr, input bit dptr, input logic [15:0] a,
                          input logic [7:0] d, input int gap);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_dptr = dptr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        step(gap);
    endtask

    initial begin
        sfr_addr = 8'h8E;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of register and strobes
        cmp("R1", "sfr_rdata reset", int'(sfr_rdata), 0);
        cmp("R1", "strobes reset", int'({rd_n, wr_n}), 3);
        step(4);                                   // R10 free-running ALE
        // R2: reserved bits read zero, other addresses ignored
        sfr_write(8'h8E, 8'hFF);
        step(1);
        sfr_write(8'h8F, 8'h00);
        step(1);
        sfr_write(8'h8E, 8'h00);
        // R3: pointer form below the boundary stays internal
        iram_rdata = 8'h5A;
        access(1'b0, 1'b1, 16'h02FF, 8'h00, 2);
        access(1'b1, 1'b1, 16'h0000, 8'h77, 2);
        // R4: pointer form at the boundary goes out; load and store
        p0_in = 8'hC3;
        access(1'b0, 1'b1, 16'h0300, 8'h00, STROBE + 5);
        access(1'b1, 1'b1, 16'hABCD, 8'h96, STROBE + 5);
        // R5: byte form with high address bits set stays internal
        access(1'b0, 1'b0, 16'hFF55, 8'h00, 2);
        access(1'b1, 1'b0, 16'h12AA, 8'h11, 2);
        // R6 R9: select bit set, byte form goes out, high port kept
        sfr_write(8'h8E, 8'h02);
        p0_in = 8'h4E;
        access(1'b1, 1'b0, 16'h0012, 8'hE1, STROBE + 5);
        access(1'b0, 1'b0, 16'h0034, 8'h00, STROBE + 5);
        access(1'b0, 1'b1, 16'h0010, 8'h00, STROBE + 5);
        // R12: second request during a running sequence is dropped
        sfr_write(8'h8E, 8'h00);
        access(1'b0, 1'b1, 16'h8000, 8'h00, 1);
        access(1'b0, 1'b0, 16'h0021, 8'h00, STROBE + 5);
        // R11: ALE suppressed, follows code-constant request
        sfr_write(8'h8E, 8'h01);
        for (int k = 0; k < 6; k++) begin
            movc_ale_req = k[0];
            step(1);
        end
        movc_ale_req = 1'b0;
        access(1'b0, 1'b1, 16'h0400, 8'h00, STROBE + 5);
        step(3);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        finished = 1;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule